// File: doc/BRIEF.md
# ECC Error Logging and Fault-Injection Controller

This block sits beside a memory port whose words carry 32 data bits and 7 check bits. Software reaches it through a simple register read/write port. Through that port it can arm a data mask and a check mask. Both masks are XORed into the next word written to the array and then clear themselves. This lets a self-test plant single-bit and double-bit faults at a chosen location. The codec that computes and checks the check bits is outside the block, and so is the memory array. The codec reports each access that found an error by pulsing a correctable (CE) or uncorrectable (UE) input, and it presents the access address, the raw data word and the raw check bits with the pulse.

For every CE or UE the block sets a sticky status bit and captures the word-aligned address, raw data and raw check bits into the register set that belongs to that error class. A CE also advances a counter that saturates at all ones. An interrupt output combines the status bits with an enable register. Byte and halfword writes are done as read-modify-write. The read phase passes through the codec, so a planted fault is reported before the new bytes are merged. The block merges the new bytes into the corrected old word on the store path.

Top module: `ecc_fault_log`

## Requirements
- R1: On a cycle with `st_valid_i` high, `st_data_o` equals the merged word XOR the data injection mask, and `st_chk_o` equals `st_chk_i` XOR the check injection mask, in the same cycle.
- R2: After a store cycle, both injection masks read zero unless software wrote that mask in the same cycle. A later store then passes data and check bits through unchanged.
- R3: The merged word takes byte lane k (bits 8k+7..8k) from `st_new_i` when `st_be_i[k]` is 1, and from `st_old_i` when it is 0. Setting `st_be_i` to 4'b1111 gives a full-word write.
- R4: Status bit 0 is CE and bit 1 is UE. A CE or UE pulse sets its bit on the next edge. Writing a 1 to a bit clears it, and writing a 0 leaves it unchanged. A pulse in the same cycle as a clear leaves the bit set.
- R5: `irq_o` is high whenever some status bit is set and its enable bit is set. Enable bit 0 is CE and bit 1 is UE. The enable register reads back the value written.
- R6: The CE counter is CNT_W bits wide (default 8). It rises by one per CE pulse and holds at 2^CNT_W-1. A software write loads it and takes priority over an increment in the same cycle.
- R7: On a CE pulse, the CE address register captures `err_addr_i` with bits 1:0 cleared. The CE data and CE check registers capture `err_data_i` and `err_chk_i`. Each new CE overwrites them.
- R8: On a UE pulse, a separate UE address, data and check register set is captured in the same way. A UE leaves the CE capture registers unchanged.
- R9: After reset, every register reads zero and `irq_o` is low.
- R10: Register indices on `reg_idx_i`: 0 status, 1 irq enable, 2 CE counter, 3/4/5 CE address/data/check, 6/7/8 UE address/data/check, 9 data mask, 10 check mask. Reads return the value on `reg_rdata_o` combinationally, with narrower fields zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_idx_i | input | 4 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| st_valid_i | input | 1 | A word is stored to the array this cycle |
| st_be_i | input | 4 | Byte enables of the store |
| st_old_i | input | 32 | Corrected old word from the read phase |
| st_new_i | input | 32 | New write data |
| st_chk_i | input | 7 | Check bits computed by the codec for the merged word |
| st_data_o | output | 32 | Data bits sent to the array |
| st_chk_o | output | 7 | Check bits sent to the array |
| ce_i | input | 1 | Correctable-error pulse from the codec |
| ue_i | input | 1 | Uncorrectable-error pulse from the codec |
| err_addr_i | input | 32 | Address of the access that reported the error |
| err_data_i | input | 32 | Raw data word of that access |
| err_chk_i | input | 7 | Raw check bits of that access |
| irq_o | output | 1 | Interrupt request |

## Verification
The store outputs are combinational, so they are checked in the same cycle as the store. The bench samples them one time step after it drives the inputs, before the clock edge consumes the masks. Status, capture registers, counter and interrupt change on the first rising edge after a pulse or register write. The bench reads them at the next falling edge, after driving `reg_idx_i`, because the read path adds no register. Mask self-clearing is checked by reading the mask register after the consuming edge and again on a following unmasked store.

// File: rtl/efl_pkg.sv
package efl_pkg;
  localparam int REG_W = 32;
  localparam int IDX_W = 4;

  typedef enum logic [IDX_W-1:0] {
    RI_STATUS = 4'd0,
    RI_IRQEN  = 4'd1,
    RI_CECNT  = 4'd2,
    RI_CEADDR = 4'd3,
    RI_CEDATA = 4'd4,
    RI_CECHK  = 4'd5,
    RI_UEADDR = 4'd6,
    RI_UEDATA = 4'd7,
    RI_UECHK  = 4'd8,
    RI_INJD   = 4'd9,
    RI_INJC   = 4'd10
  } reg_idx_e;
endpackage

// File: rtl/efl_merge.sv
module efl_merge #(
  parameter int DW = 32
) (
  input  logic [DW/8-1:0] be_i,
  input  logic [DW-1:0]   old_i,
  input  logic [DW-1:0]   new_i,
  output logic [DW-1:0]   word_o
);
  localparam int LANES = DW / 8;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign word_o[8*k +: 8] = be_i[k] ? new_i[8*k +: 8] : old_i[8*k +: 8];
  end
endmodule

// File: rtl/efl_sat_cnt.sv
module efl_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_o <= '0;
    else if (wr_i)                cnt_o <= wdata_i;
    else if (inc_i && cnt_o != MAX) cnt_o <= cnt_o + 1'b1;
  end

  // R6 saturation and step
  a_r6_cnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_i && cnt_o == MAX) |=> cnt_o == MAX);
  a_r6_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_i && cnt_o != MAX) |=> cnt_o == $past(cnt_o) + 1'b1);
  a_r6_cnt_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cnt_o == $past(wdata_i));
endmodule

// File: rtl/efl_capture.sv
module efl_capture #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hit_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic [CW-1:0] chk_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] chk_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      data_o <= '0;
      chk_o  <= '0;
    end else if (hit_i) begin
      addr_o <= {addr_i[AW-1:2], 2'b00};
      data_o <= data_i;
      chk_o  <= chk_i;
    end
  end

  // R7 / R8 capture on every hit
  a_r7_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> (addr_o[1:0] == 2'b00 && addr_o[AW-1:2] == $past(addr_i[AW-1:2])
               && data_o == $past(data_i) && chk_o == $past(chk_i)));
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i |=> $stable(addr_o) && $stable(data_o) && $stable(chk_o));
endmodule

// File: rtl/ecc_fault_log.sv
module ecc_fault_log
  import efl_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic [3:0]  reg_idx_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        st_valid_i,
  input  logic [3:0]  st_be_i,
  input  logic [31:0] st_old_i,
  input  logic [31:0] st_new_i,
  input  logic [6:0]  st_chk_i,
  output logic [31:0] st_data_o,
  output logic [6:0]  st_chk_o,
  input  logic        ce_i,
  input  logic        ue_i,
  input  logic [31:0] err_addr_i,
  input  logic [31:0] err_data_i,
  input  logic [6:0]  err_chk_i,
  output logic        irq_o
);
  localparam int DW = 32;
  localparam int CW = 7;
  localparam int AW = 32;

  logic [1:0]       sts_q, en_q;
  logic [DW-1:0]    inj_d_q, merged;
  logic [CW-1:0]    inj_c_q;
  logic [CNT_W-1:0] cnt;
  logic [AW-1:0]    ce_addr, ue_addr;
  logic [DW-1:0]    ce_data, ue_data;
  logic [CW-1:0]    ce_chk, ue_chk;
  logic             wr_sts, wr_en, wr_cnt, wr_injd, wr_injc;

  assign wr_sts  = reg_wr_i && reg_idx_i == RI_STATUS;
  assign wr_en   = reg_wr_i && reg_idx_i == RI_IRQEN;
  assign wr_cnt  = reg_wr_i && reg_idx_i == RI_CECNT;
  assign wr_injd = reg_wr_i && reg_idx_i == RI_INJD;
  assign wr_injc = reg_wr_i && reg_idx_i == RI_INJC;

  efl_merge #(.DW(DW)) u_merge (
    .be_i(st_be_i), .old_i(st_old_i), .new_i(st_new_i), .word_o(merged)
  );

  assign st_data_o = st_valid_i ? merged ^ inj_d_q : merged;
  assign st_chk_o  = st_valid_i ? st_chk_i ^ inj_c_q : st_chk_i;

  // masks are one-shot: consumed by the next store unless rewritten
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inj_d_q <= '0;
      inj_c_q <= '0;
    end else begin
      if (wr_injd)         inj_d_q <= reg_wdata_i[DW-1:0];
      else if (st_valid_i) inj_d_q <= '0;
      if (wr_injc)         inj_c_q <= reg_wdata_i[CW-1:0];
      else if (st_valid_i) inj_c_q <= '0;
    end
  end

  // status: event set has priority over write-one-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q[0] <= ce_i | (sts_q[0] & ~(wr_sts & reg_wdata_i[0]));
      sts_q[1] <= ue_i | (sts_q[1] & ~(wr_sts & reg_wdata_i[1]));
      if (wr_en) en_q <= reg_wdata_i[1:0];
    end
  end

  assign irq_o = |(sts_q & en_q);

  efl_sat_cnt #(.W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .wr_i(wr_cnt), .wdata_i(reg_wdata_i[CNT_W-1:0]),
    .inc_i(ce_i), .cnt_o(cnt)
  );

  efl_capture #(.AW(AW), .DW(DW), .CW(CW)) u_cap_ce (
    .clk_i, .rst_ni, .hit_i(ce_i), .addr_i(err_addr_i), .data_i(err_data_i),
    .chk_i(err_chk_i), .addr_o(ce_addr), .data_o(ce_data), .chk_o(ce_chk)
  );

  efl_capture #(.AW(AW), .DW(DW), .CW(CW)) u_cap_ue (
    .clk_i, .rst_ni, .hit_i(ue_i), .addr_i(err_addr_i), .data_i(err_data_i),
    .chk_i(err_chk_i), .addr_o(ue_addr), .data_o(ue_data), .chk_o(ue_chk)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_idx_i)
      RI_STATUS: reg_rdata_o[1:0]       = sts_q;
      RI_IRQEN:  reg_rdata_o[1:0]       = en_q;
      RI_CECNT:  reg_rdata_o[CNT_W-1:0] = cnt;
      RI_CEADDR: reg_rdata_o            = ce_addr;
      RI_CEDATA: reg_rdata_o            = ce_data;
      RI_CECHK:  reg_rdata_o[CW-1:0]    = ce_chk;
      RI_UEADDR: reg_rdata_o            = ue_addr;
      RI_UEDATA: reg_rdata_o            = ue_data;
      RI_UECHK:  reg_rdata_o[CW-1:0]    = ue_chk;
      RI_INJD:   reg_rdata_o            = inj_d_q;
      RI_INJC:   reg_rdata_o[CW-1:0]    = inj_c_q;
      default:   reg_rdata_o            = '0;
    endcase
  end

  // R2 masks consumed by a store
  a_r2_mask_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_i && !wr_injd && !wr_injc) |=> (inj_d_q == '0 && inj_c_q == '0));
  // R4 event sets status even against a clear
  a_r4_ce_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i |=> sts_q[0]);
  a_r4_ue_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ue_i |=> sts_q[1]);
  // R5 enabled event raises the interrupt
  a_r5_irq_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && en_q[0] && !wr_en) |=> irq_o);
  a_r5_irq_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == 2'b00) |-> !irq_o);
endmodule

// File: tb/ecc_fault_log_test.sv
module ecc_fault_log_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        st_valid = 1'b0;
  logic [3:0]  st_be = '0;
  logic [31:0] st_old = '0, st_new = '0;
  logic [6:0]  st_chk = '0;
  logic [31:0] st_data;
  logic [6:0]  st_chk_out;
  logic        ce = 1'b0, ue = 1'b0;
  logic [31:0] e_addr = '0, e_data = '0;
  logic [6:0]  e_chk = '0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ecc_fault_log uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_idx_i(reg_idx),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .st_valid_i(st_valid),
    .st_be_i(st_be), .st_old_i(st_old), .st_new_i(st_new), .st_chk_i(st_chk),
    .st_data_o(st_data), .st_chk_o(st_chk_out), .ce_i(ce), .ue_i(ue),
    .err_addr_i(e_addr), .err_data_i(e_data), .err_chk_i(e_chk), .irq_o(irq)
  );

  typedef struct packed {
    logic [3:0]  be;
    logic [31:0] old_w;
    logic [31:0] new_w;
    logic [31:0] dmask;
    logic [6:0]  cmask;
    logic [6:0]  chk;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{4'b1111, 32'h0000_0000, 32'hDEAD_BEEF, 32'h0000_0001, 7'h00, 7'h15},
    '{4'b1111, 32'h1234_5678, 32'hA5A5_5A5A, 32'h8000_0004, 7'h00, 7'h2A},
    '{4'b1111, 32'hFFFF_FFFF, 32'h0F0F_F0F0, 32'h0000_0000, 7'h41, 7'h7F},
    '{4'b0001, 32'h1122_3344, 32'hAABB_CCDD, 32'h0000_0100, 7'h00, 7'h01},
    '{4'b1100, 32'h1122_3344, 32'hAABB_CCDD, 32'h0000_0000, 7'h03, 7'h00},
    '{4'b0110, 32'hCAFE_F00D, 32'h0BAD_1DEA, 32'h0001_0000, 7'h10, 7'h33}
  };

  function automatic logic [31:0] lane_mix(logic [3:0] be, logic [31:0] o, logic [31:0] n);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[8*k +: 8] = be[k] ? n[8*k +: 8] : o[8*k +: 8];
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] idx, logic [31:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = idx; reg_wdata = v;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic rd(string req, logic [3:0] idx, logic [31:0] exp);
    @(negedge clk);
    reg_idx = idx;
    #1 check(req, reg_rdata, exp);
  endtask

  task automatic pulse(bit c, bit u, logic [31:0] a, logic [31:0] d, logic [6:0] k);
    @(negedge clk);
    ce = c; ue = u; e_addr = a; e_data = d; e_chk = k;
    @(posedge clk);
    #1 ce = 1'b0; ue = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R9 reset state
    for (int i = 0; i <= 10; i++) rd("R9 reset reg", 4'(i), 32'h0);
    check("R9 irq", {31'b0, irq}, 32'h0);

    // R1 R3 store vectors
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].dmask != 0) wr(4'd9, VECS[i].dmask);
      if (VECS[i].cmask != 0) wr(4'd10, {25'b0, VECS[i].cmask});
      @(negedge clk);
      st_valid = 1'b1; st_be = VECS[i].be; st_old = VECS[i].old_w;
      st_new = VECS[i].new_w; st_chk = VECS[i].chk;
      #1;
      check("R1 R3 store data", st_data,
            lane_mix(VECS[i].be, VECS[i].old_w, VECS[i].new_w) ^ VECS[i].dmask);
      check("R1 store chk", {25'b0, st_chk_out}, {25'b0, VECS[i].chk ^ VECS[i].cmask});
      @(posedge clk);
      #1 st_valid = 1'b0;
      rd("R2 data mask cleared", 4'd9, 32'h0);
      rd("R2 chk mask cleared", 4'd10, 32'h0);
    end

    // R2 next store is clean
    @(negedge clk);
    st_valid = 1'b1; st_be = 4'hF; st_new = 32'h600D_600D; st_chk = 7'h55;
    #1;
    check("R2 clean store data", st_data, 32'h600D_600D);
    check("R2 clean store chk", {25'b0, st_chk_out}, 32'h55);
    @(posedge clk);
    #1 st_valid = 1'b0;

    // R7 CE capture, R6 count
    pulse(1, 0, 32'h0000_1003, 32'h1357_9BDF, 7'h2C);
    rd("R4 ce status", 4'd0, 32'h1);
    rd("R7 ce addr", 4'd3, 32'h0000_1000);
    rd("R7 ce data", 4'd4, 32'h1357_9BDF);
    rd("R7 ce chk", 4'd5, 32'h2C);
    rd("R6 count one", 4'd2, 32'h1);
    check("R5 irq masked", {31'b0, irq}, 32'h0);

    // R8 UE capture, CE set untouched
    pulse(0, 1, 32'h0000_2FFE, 32'h2468_ACE0, 7'h71);
    rd("R4 both status", 4'd0, 32'h3);
    rd("R8 ue addr", 4'd6, 32'h0000_2FFC);
    rd("R8 ue data", 4'd7, 32'h2468_ACE0);
    rd("R8 ue chk", 4'd8, 32'h71);
    rd("R8 ce addr kept", 4'd3, 32'h0000_1000);
    rd("R6 ue no count", 4'd2, 32'h1);

    // R7 overwrite on new CE
    pulse(1, 0, 32'h0000_0041, 32'h0000_00FF, 7'h01);
    rd("R7 ce addr new", 4'd3, 32'h0000_0040);

    // R5 enable and irq
    wr(4'd1, 32'h1);
    rd("R5 en readback", 4'd1, 32'h1);
    check("R5 irq on", {31'b0, irq}, 32'h1);

    // R4 write-one-to-clear
    wr(4'd0, 32'h0);
    rd("R4 zero write no effect", 4'd0, 32'h3);
    wr(4'd0, 32'h2);
    rd("R4 clear ue", 4'd0, 32'h1);
    check("R5 irq still on", {31'b0, irq}, 32'h1);
    wr(4'd0, 32'h1);
    rd("R4 clear ce", 4'd0, 32'h0);
    check("R5 irq off", {31'b0, irq}, 32'h0);

    // R4 set wins over clear
    wr(4'd0, 32'h1);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = 4'd0; reg_wdata = 32'h1; ce = 1'b1;
    @(posedge clk);
    #1 reg_wr = 1'b0; ce = 1'b0;
    rd("R4 set beats clear", 4'd0, 32'h1);

    // R6 saturation and write priority
    wr(4'd2, 32'hFE);
    rd("R6 load", 4'd2, 32'hFE);
    pulse(1, 0, 32'h0, 32'h0, 7'h0);
    rd("R6 reach max", 4'd2, 32'hFF);
    pulse(1, 0, 32'h0, 32'h0, 7'h0);
    rd("R6 hold max", 4'd2, 32'hFF);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = 4'd2; reg_wdata = 32'h5; ce = 1'b1;
    @(posedge clk);
    #1 reg_wr = 1'b0; ce = 1'b0;
    rd("R6 write wins", 4'd2, 32'h5);

    // R10 unused index reads zero
    rd("R10 unused index", 4'd15, 32'h0);

    finish_run();
  end
endmodule